// File: doc/BRIEF.md
# Freezable Statistics Counter Bank

This block keeps one event counter per frame statistic, split into a transmit group and a receive group. Each cycle, a one-hot-per-counter event vector says which statistics saw an event. A host reaches the bank through a simple register port. Address 0 is a mode register. Address 1+i reads or writes counter i directly.

The mode register carries a freeze control. While the bank is frozen, every counter holds its value, so the host can read a snapshot that is consistent across all counters. Events that arrive during the freeze are not lost. Each counter has its own event queue, which records them. When the freeze ends, the queued events are added into their counters in a single cycle. If any queue fills while the bank is frozen, the hardware ends the freeze on its own. A later read of the freeze bit then returns zero, which tells the host that its snapshot may not have held. Two write-only mode bits clear a whole group of counters at one clock edge.

A small controller sequences the bank with three named states:
- RUN: events are counted directly.
- HOLD: counters are frozen and events are queued.
- FLUSH: the queued events are drained into the counters.

The transitions are:
- RUN→HOLD and FLUSH→HOLD on a mode write that sets freeze.
- RUN→RUN and FLUSH→RUN otherwise.
- HOLD→FLUSH on a mode write that clears freeze, or when any queue fills (auto-release).
- HOLD→HOLD otherwise.

Top module: `stat_ctr_bank`

## Requirements
- R1: After reset every counter reads 0 and the mode register reads 0.
- R2: In RUN or FLUSH, an event on bit i of `ev_i` adds one to counter i, visible after the next clock edge. Counters wrap modulo 2^CW.
- R3: A mode write with bit 2 set enters HOLD from the following cycle. While in HOLD, counters do not advance on events, and the mode register reads bit 2 as 1.
- R4: A mode write with bit 2 clear, made during HOLD, moves the bank to FLUSH. At the end of the FLUSH cycle each counter has added every event queued during HOLD, including any event in the release-write cycle, plus its own FLUSH-cycle event.
- R5: During HOLD, an event that brings any queue to DEPTH entries forces FLUSH at the next edge. Bit 2 then reads 0, and no queued event is lost.
- R6: Mode bit 0 clears every receive counter (indices N_TX and up), and mode bit 1 clears every transmit counter (indices below N_TX). Setting both clears both groups at the same edge. Events in the clear cycle are dropped for the cleared counters. Bits 0 and 1 always read 0.
- R7: A clear written together with a freeze release discards the queued events of the cleared group. The other group still drains its queued events.
- R8: A host write to address 1+i loads counter i with the written data, plus one if counter i has an event in the same cycle and the bank is not in HOLD. In HOLD, the written value is loaded and the event is queued.
- R9: Reads are combinational. Address 0 returns the mode register with the freeze state in bit 2. Address 1+i returns counter i. Any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | N_TX+N_RX | Per-counter event strobes; transmit counters first |
| host_we | input | 1 | Host write strobe |
| host_addr | input | AW | Host register address |
| host_wdata | input | CW | Host write data |
| host_rdata | output | CW | Host read data, combinational from host_addr |

## Verification
A counter update, whether from an event or a write, is due one clock edge after its input cycle. A freeze or release write changes bit 2 after that same edge. Queued events appear one edge later still, at the end of the FLUSH cycle, and an auto-release takes the same two edges. The bench drives each stimulus in the low clock phase and lets exactly one rising edge pass. In the next low phase it idles the inputs and sweeps every address. It compares each read against a reference model that was advanced by the same single edge, so each result is sampled in the cycle it is due.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;

    typedef enum logic [1:0] {
        FZ_RUN   = 2'd0,
        FZ_HOLD  = 2'd1,
        FZ_FLUSH = 2'd2
    } fz_state_e;

    localparam int MODE_CLR_RX  = 0;
    localparam int MODE_CLR_TX  = 1;
    localparam int MODE_FREEZE  = 2;

endpackage

// File: rtl/stat_freeze_fsm.sv
module stat_freeze_fsm
    import stat_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_we,
    input  logic freeze_bit,
    input  logic any_fill,
    output logic hold_o,
    output logic flush_o
);

    fz_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FZ_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FZ_RUN, FZ_FLUSH: begin
                if (mode_we && freeze_bit) state_d = FZ_HOLD;
                else                       state_d = FZ_RUN;
            end
            FZ_HOLD: begin
                if (any_fill || (mode_we && !freeze_bit)) state_d = FZ_FLUSH;
                else                                      state_d = FZ_HOLD;
            end
            default: state_d = FZ_RUN;
        endcase
    end

    always_comb begin
        hold_o  = (state_q == FZ_HOLD);
        flush_o = (state_q == FZ_FLUSH);
    end

    // R4: the drain lasts exactly one cycle
    a_r4_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    // R5: a filling queue ends the freeze at the next edge
    a_r5_fill_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && any_fill) |=> flush_o);

    // R3: with no write and no fill the freeze persists
    a_r3_hold_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && !any_fill && !mode_we) |=> hold_o);

endmodule

// File: rtl/stat_evq.sv
module stat_evq #(
    parameter int DEPTH = 4,
    parameter int QW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_i,
    input  logic          ev_i,
    input  logic          clr_i,
    output logic [QW-1:0] occ_o,
    output logic          fill_o
);

    logic [QW-1:0] occ_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      occ_q <= '0;
        else if (clr_i)  occ_q <= '0;
        else if (hold_i) occ_q <= occ_q + QW'(ev_i);
        else             occ_q <= '0;
    end

    assign occ_o  = occ_q;
    assign fill_o = hold_i && ev_i && !clr_i && (occ_q == QW'(DEPTH - 1));

    // R5: occupancy never exceeds the queue depth
    a_r5_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= QW'(DEPTH));

    // R4: outside a freeze the queue is left empty
    a_r4_empty_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_i |=> (occ_q == '0));

endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
    parameter int CW = 16,
    parameter int QW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_i,
    input  logic          hold_i,
    input  logic          flush_i,
    input  logic          clr_i,
    input  logic          wr_i,
    input  logic [CW-1:0] wdata_i,
    input  logic [QW-1:0] pend_i,
    output logic [CW-1:0] cnt_o
);

    logic [CW-1:0] cnt_q, cnt_d, base, inc, drain;

    always_comb begin
        base  = wr_i ? wdata_i : cnt_q;
        inc   = CW'(ev_i && !hold_i);
        drain = flush_i ? CW'(pend_i) : '0;
        cnt_d = clr_i ? '0 : (base + inc + drain);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R6: a group clear leaves the counter at zero
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

    // R3: a frozen counter stays put unless written or cleared
    a_r3_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !wr_i && !clr_i) |=> $stable(cnt_q));

    // R8: a write in RUN loads the data plus a same-cycle event
    a_r8_write_plus_event: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i && !hold_i && !flush_i) |=>
        (cnt_q == $past(wdata_i) + CW'($past(ev_i))));

endmodule

// File: rtl/stat_ctr_bank.sv
module stat_ctr_bank
    import stat_bank_pkg::*;
#(
    parameter int N_TX  = 2,
    parameter int N_RX  = 2,
    parameter int CW    = 16,
    parameter int DEPTH = 4,
    parameter int AW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_TX+N_RX-1:0] ev_i,
    input  logic                 host_we,
    input  logic [AW-1:0]        host_addr,
    input  logic [CW-1:0]        host_wdata,
    output logic [CW-1:0]        host_rdata
);

    localparam int N  = N_TX + N_RX;
    localparam int QW = $clog2(DEPTH + 1);

    logic          mode_we, clr_tx, clr_rx, hold, flush, any_fill;
    logic [N-1:0]  grp_clr, cnt_wr, fill;
    logic [QW-1:0] pend [N];
    logic [CW-1:0] cnt  [N];

    assign mode_we  = host_we && (host_addr == '0);
    assign clr_tx   = mode_we && host_wdata[MODE_CLR_TX];
    assign clr_rx   = mode_we && host_wdata[MODE_CLR_RX];
    assign any_fill = |fill;

    stat_freeze_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .freeze_bit (host_wdata[MODE_FREEZE]),
        .any_fill   (any_fill),
        .hold_o     (hold),
        .flush_o    (flush)
    );

    for (genvar i = 0; i < N; i++) begin : g_ctr
        if (i < N_TX) begin : g_tx
            assign grp_clr[i] = clr_tx;
        end else begin : g_rx
            assign grp_clr[i] = clr_rx;
        end
        assign cnt_wr[i] = host_we && (host_addr == AW'(i + 1));

        stat_evq #(.DEPTH(DEPTH), .QW(QW)) u_q (
            .clk    (clk),
            .rst_n  (rst_n),
            .hold_i (hold),
            .ev_i   (ev_i[i]),
            .clr_i  (grp_clr[i]),
            .occ_o  (pend[i]),
            .fill_o (fill[i])
        );

        stat_counter #(.CW(CW), .QW(QW)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_i    (ev_i[i]),
            .hold_i  (hold),
            .flush_i (flush),
            .clr_i   (grp_clr[i]),
            .wr_i    (cnt_wr[i]),
            .wdata_i (host_wdata),
            .pend_i  (pend[i]),
            .cnt_o   (cnt[i])
        );
    end

    always_comb begin
        host_rdata = '0;
        if (host_addr == '0) host_rdata[MODE_FREEZE] = hold;
        for (int i = 0; i < N; i++) begin
            if (host_addr == AW'(i + 1)) host_rdata = cnt[i];
        end
    end

    // R6: both group clears in one write reach every counter at the same edge
    a_r6_dual_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tx && clr_rx) |=> (cnt[0] == '0 && cnt[N-1] == '0));

    // R7: a clear that coincides with a release leaves the cleared queue empty
    a_r7_clear_drops_queue: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && clr_rx && !host_wdata[MODE_FREEZE]) |=> (flush && pend[N-1] == '0));

endmodule

// File: tb/stat_ctr_bank_bench.sv
module stat_ctr_bank_bench;

    localparam int N_TX  = 2;
    localparam int N_RX  = 2;
    localparam int N     = N_TX + N_RX;
    localparam int CW    = 16;
    localparam int DEPTH = 4;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ev_i = '0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [CW-1:0] host_wdata = '0;
    logic [CW-1:0] host_rdata;

    int checks = 0;
    int errors = 0;

    // reference model: st 0 = RUN, 1 = HOLD, 2 = FLUSH
    logic [CW-1:0] m_cnt [N];
    int            m_occ [N];
    int            m_st;

    always #10 clk = ~clk;

    stat_ctr_bank #(.N_TX(N_TX), .N_RX(N_RX), .CW(CW), .DEPTH(DEPTH), .AW(AW)) u_stat_ctr_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev_i),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    task automatic chk(input logic [CW-1:0] act, input logic [CW-1:0] exp, input string tag, input int addr);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr %0d: actual %h expected %h", tag, addr, act, exp);
        end
    endtask

    // R9: sweep every mapped address plus one unmapped one
    task automatic check_all(input string tag);
        for (int a = 0; a <= N + 1; a++) begin
            logic [CW-1:0] exp;
            host_addr = AW'(a);
            #1;
            if (a == 0)      exp = CW'((m_st == 1) ? 4 : 0);
            else if (a <= N) exp = m_cnt[a-1];
            else             exp = '0;
            chk(host_rdata, exp, tag, a);
        end
    endtask

    // called in the low phase; applies one cycle of stimulus and checks after the edge
    task automatic step(input logic [N-1:0] ev, input logic we, input logic [AW-1:0] addr,
                        input logic [CW-1:0] wd, input string tag);
        logic [CW-1:0] n_cnt [N];
        int            n_occ [N];
        int            n_st;
        logic          mwe, hold, flush, fill;
        logic [N-1:0]  ci;
        mwe   = we && (addr == 0);
        hold  = (m_st == 1);
        flush = (m_st == 2);
        fill  = 1'b0;
        for (int i = 0; i < N; i++) ci[i] = mwe && ((i < N_TX) ? wd[1] : wd[0]);
        for (int i = 0; i < N; i++)
            if (hold && ev[i] && !ci[i] && m_occ[i] == DEPTH - 1) fill = 1'b1;
        for (int i = 0; i < N; i++) begin
            logic [CW-1:0] base;
            base = (we && addr == AW'(i + 1)) ? wd : m_cnt[i];
            n_cnt[i] = ci[i] ? '0 : base + CW'((!hold && ev[i]) ? 1 : 0) + CW'(flush ? m_occ[i] : 0);
            n_occ[i] = ci[i] ? 0 : (hold ? m_occ[i] + int'(ev[i]) : 0);
        end
        if (m_st != 1) n_st = (mwe && wd[2]) ? 1 : 0;
        else           n_st = (fill || (mwe && !wd[2])) ? 2 : 1;
        ev_i = ev; host_we = we; host_addr = addr; host_wdata = wd;
        @(posedge clk);
        for (int i = 0; i < N; i++) begin m_cnt[i] = n_cnt[i]; m_occ[i] = n_occ[i]; end
        m_st = n_st;
        @(negedge clk);
        ev_i = '0; host_we = 1'b0; host_wdata = '0;
        check_all(tag);
    endtask

    // fields: ev[4] | we | addr[4] | wdata[16] | expected freeze bit after the step
    localparam int VW = 26;
    localparam logic [VW-1:0] VEC [0:15] = '{
        {4'b1111, 1'b0, 4'd0, 16'd0, 1'b0},
        {4'b0101, 1'b0, 4'd0, 16'd0, 1'b0},
        {4'b0011, 1'b1, 4'd0, 16'd4, 1'b1},
        {4'b1111, 1'b0, 4'd0, 16'd0, 1'b1},
        {4'b1000, 1'b0, 4'd0, 16'd0, 1'b1},
        {4'b0000, 1'b0, 4'd0, 16'd0, 1'b1},
        {4'b0001, 1'b1, 4'd0, 16'd0, 1'b0},
        {4'b0010, 1'b0, 4'd0, 16'd0, 1'b0},
        {4'b1111, 1'b0, 4'd0, 16'd0, 1'b0},
        {4'b0000, 1'b1, 4'd0, 16'd4, 1'b1},
        {4'b0100, 1'b0, 4'd0, 16'd0, 1'b1},
        {4'b0100, 1'b0, 4'd0, 16'd0, 1'b1},
        {4'b0100, 1'b0, 4'd0, 16'd0, 1'b1},
        {4'b0100, 1'b0, 4'd0, 16'd0, 1'b0},
        {4'b0100, 1'b0, 4'd0, 16'd0, 1'b0},
        {4'b0000, 1'b0, 4'd0, 16'd0, 1'b0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_cnt[i] = '0; m_occ[i] = 0; end
        m_st = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // table: count, freeze, hold, release, drain, auto-release on full queue
        for (int k = 0; k < 16; k++) begin
            step(VEC[k][25:22], VEC[k][21], VEC[k][20:17], VEC[k][16:1], "R2 R3 R4 R5 table");
            host_addr = '0;
            #1;
            chk(CW'(host_rdata[2]), CW'(VEC[k][0]), "R3 R5 freeze bit", 0);
        end

        // R2: wrap at 2^CW
        step(4'b0000, 1'b1, 4'd1, 16'hFFFF, "R8 load");
        step(4'b0001, 1'b0, 4'd0, 16'd0,    "R2 wrap");

        // R8: write plus same-cycle event in RUN
        step(4'b0100, 1'b1, 4'd3, 16'd100,  "R8 write+event");

        // R8: write during HOLD queues the event
        step(4'b0000, 1'b1, 4'd0, 16'd4,    "R3 freeze");
        step(4'b0001, 1'b1, 4'd1, 16'd50,   "R8 write in hold");
        step(4'b0000, 1'b1, 4'd0, 16'd0,    "R4 release");
        step(4'b0000, 1'b0, 4'd0, 16'd0,    "R4 drain");

        // R6: both groups cleared together, events in that cycle dropped
        step(4'b1111, 1'b1, 4'd0, 16'd3,    "R6 clear both");
        step(4'b1010, 1'b0, 4'd0, 16'd0,    "R2 count");
        step(4'b1111, 1'b1, 4'd0, 16'd2,    "R6 clear tx only");

        // R7: clear of receive group with release drops its queue only
        step(4'b0000, 1'b1, 4'd0, 16'd4,    "R3 freeze");
        step(4'b1111, 1'b0, 4'd0, 16'd0,    "R3 hold");
        step(4'b1111, 1'b0, 4'd0, 16'd0,    "R3 hold");
        step(4'b1111, 1'b1, 4'd0, 16'd1,    "R7 clear rx with release");
        step(4'b0000, 1'b0, 4'd0, 16'd0,    "R7 drain tx only");

        // R6: clear bits read back as zero; R9 unmapped addresses
        host_addr = 4'd0; #1;
        chk(host_rdata & 16'h0003, 16'd0, "R6 clear bits read zero", 0);
        host_addr = 4'd15; #1;
        chk(host_rdata, 16'd0, "R9 unmapped", 15);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule